// File: doc/BRIEF.md
# Audio Noise Gate Controller

This block watches a stream of signed audio samples and decides when the signal has gone quiet. Each valid sample's magnitude is compared with a threshold chosen by a 5-bit code on a logarithmic scale. When enough consecutive samples have stayed under that threshold, the gate engages. It then acts on the output samples and on a gain index that travels alongside them. The qualification window is set by a parameter, given in samples: 12000 samples gives 250 ms at 48 kHz.

Four gate behaviours can be chosen. The gain can be frozen. The output can be silenced. The gain can be ramped down one step at a time to a floor. The gain can be ramped down and the output then silenced once the floor is reached. Any sample whose magnitude reaches the threshold opens the gate again at once, and the gain index then follows its input again. With the enable low, samples and gain pass straight through. The block sits between a sample source and the gain stage it steers. Every result appears one clock after its input sample.

Top module: `audio_noise_gate`

## Requirements
- R1: During reset and after it, before the first valid sample, out_valid, out_sample, out_gain and gate_active are all zero.
- R2: out_valid is high exactly one clock after each cycle with in_valid high, and low otherwise. The other outputs change only on those cycles and hold their values in between.
- R3: While gate_en is 0, out_sample equals in_sample, out_gain equals gain_in, and gate_active stays 0.
- R4: A sample counts as quiet when its absolute value is strictly below the threshold. Threshold code k stands for -76.5 + 1.5*k dB of a 24-bit full scale. Code 0 is 1255, code 11 is 8389 and code 31 is 265271. Negative samples are judged by their magnitude, and -2^23 is always loud.
- R5: The gate engages on the HOLD_SAMPLES-th consecutive quiet valid sample. That sample's own output is already gated.
- R6: A loud sample clears the quiet count and releases the gate on that same sample. Its output is in_sample and gain_in, with gate_active 0.
- R7: Mode 2'b00 (hold): while gated, out_gain stays at the gain_in value of the engaging sample, and samples pass unchanged.
- R8: Mode 2'b01 (mute): while gated, out_sample is 0 and out_gain holds as in R7.
- R9: Mode 2'b10 (fade): while gated, the gain index starts at the engaging sample's gain_in. It drops by one on every FADE_SAMPLES-th gated sample after the engaging one and stops at GAIN_MIN. Samples pass unchanged.
- R10: Mode 2'b11 (fade then mute): the gain follows R9, and out_sample is 0 on every gated sample whose gain index equals GAIN_MIN.
- R11: Once the gate releases, out_gain follows gain_in again, and muting stops with the releasing sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| gain_in | input | GAIN_W | Gain index supplied upstream |
| gate_en | input | 1 | Gate function on (1) or off (0) |
| gate_mode | input | 2 | Gate behaviour: 00 hold, 01 mute, 10 fade, 11 fade then mute |
| thr_code | input | 5 | Threshold code, 1.5 dB per step |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W | Processed sample |
| out_gain | output | GAIN_W | Gain index after gating |
| gate_active | output | 1 | Gate engaged for the current output |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-cycle latency, the bypass with the gate disabled, immediate release on a loud sample, the quiet counter staying within its window, engagement happening only at the end of a full window, a gain index that never rises during a fade, a frozen gain in hold mode, and silence in mute mode. Other behaviours can only be shown by the bench's scenarios. These are the exact threshold boundaries for several codes, including negative and full-scale samples. They also include the cycle on which the gate engages after a broken quiet run, the spacing of fade steps, the point where fade-then-mute starts silencing, and the gain returning after release.

// File: rtl/ngate_pkg.sv
package ngate_pkg;

    typedef enum logic [1:0] {
        GT_HOLD      = 2'b00,
        GT_MUTE      = 2'b01,
        GT_FADE      = 2'b10,
        GT_FADE_MUTE = 2'b11
    } gate_mode_e;

    localparam int REF_W = 24;

    // Linear magnitude for each 1.5 dB threshold step on a 24-bit full scale.
    function automatic logic [REF_W-1:0] thr_level(input logic [4:0] code);
        logic [REF_W-1:0] v;
        case (code)
            5'd0:  v = 24'd1255;
            5'd1:  v = 24'd1492;
            5'd2:  v = 24'd1773;
            5'd3:  v = 24'd2107;
            5'd4:  v = 24'd2504;
            5'd5:  v = 24'd2976;
            5'd6:  v = 24'd3537;
            5'd7:  v = 24'd4204;
            5'd8:  v = 24'd4997;
            5'd9:  v = 24'd5939;
            5'd10: v = 24'd7058;
            5'd11: v = 24'd8389;
            5'd12: v = 24'd9970;
            5'd13: v = 24'd11849;
            5'd14: v = 24'd14083;
            5'd15: v = 24'd16737;
            5'd16: v = 24'd19892;
            5'd17: v = 24'd23642;
            5'd18: v = 24'd28099;
            5'd19: v = 24'd33395;
            5'd20: v = 24'd39690;
            5'd21: v = 24'd47172;
            5'd22: v = 24'd56065;
            5'd23: v = 24'd66633;
            5'd24: v = 24'd79193;
            5'd25: v = 24'd94121;
            5'd26: v = 24'd111862;
            5'd27: v = 24'd132948;
            5'd28: v = 24'd158009;
            5'd29: v = 24'd187794;
            5'd30: v = 24'd223194;
            default: v = 24'd265271;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ngate_level.sv
module ngate_level
    import ngate_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [4:0]        code,
    output logic              quiet
);
    localparam int SHIFT = DATA_W - REF_W;

    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] thr_scaled;

    always_comb begin
        // Two's complement negate; the most negative value maps to 2^(W-1).
        mag        = sample[DATA_W-1] ? (~sample + 1'b1) : sample;
        thr_scaled = DATA_W'(thr_level(code)) << SHIFT;
        quiet      = (mag < thr_scaled);
    end

endmodule

// File: rtl/ngate_qual.sv
module ngate_qual #(
    parameter int HOLD_SAMPLES = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic enable,
    input  logic quiet,
    output logic act_next,
    output logic act_now
);
    localparam int CNT_W = (HOLD_SAMPLES > 1) ? $clog2(HOLD_SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_SAMPLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (!enable || !quiet) begin
                st_d = '0;
            end else if (!st_q.act) begin
                if (st_q.cnt == LAST) st_d.act = 1'b1;
                else                  st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_next = st_d.act;
    assign act_now  = st_q.act;

    assert_loud_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !quiet) |=> !st_q.act);

    assert_off_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !enable) |=> (!st_q.act && st_q.cnt == '0));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    assert_engage_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> ($past(st_q.cnt) == LAST));

endmodule

// File: rtl/ngate_fade.sv
module ngate_fade
    import ngate_pkg::*;
#(
    parameter int GAIN_W       = 6,
    parameter int FADE_SAMPLES = 480,
    parameter int GAIN_MIN     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  gate_mode_e        mode,
    input  logic              act_next,
    input  logic              act_now,
    input  logic [GAIN_W-1:0] gain_in,
    output logic [GAIN_W-1:0] held_next,
    output logic              at_min
);
    localparam int FC_W = (FADE_SAMPLES > 1) ? $clog2(FADE_SAMPLES) : 1;
    localparam logic [FC_W-1:0]   FLAST = FC_W'(FADE_SAMPLES - 1);
    localparam logic [GAIN_W-1:0] FLOOR = GAIN_W'(GAIN_MIN);

    typedef struct packed {
        logic [GAIN_W-1:0] held;
        logic [FC_W-1:0]   fcnt;
    } fade_t;

    fade_t st_d, st_q;
    logic  fading;

    assign fading = (mode == GT_FADE) || (mode == GT_FADE_MUTE);

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (!act_next) begin
                st_d.fcnt = '0;
            end else if (!act_now) begin
                st_d.held = gain_in;
                st_d.fcnt = '0;
            end else if (fading) begin
                if (st_q.fcnt == FLAST) begin
                    st_d.fcnt = '0;
                    if (st_q.held > FLOOR) st_d.held = st_q.held - 1'b1;
                end else begin
                    st_d.fcnt = st_q.fcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_next = st_d.held;
    assign at_min    = (st_d.held <= FLOOR);

    assert_fade_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && act_now && act_next) |=> (st_q.held <= $past(st_q.held)));

    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && act_now && act_next && !fading) |=> $stable(st_q.held));

endmodule

// File: rtl/audio_noise_gate.sv
module audio_noise_gate
    import ngate_pkg::*;
#(
    parameter int DATA_W       = 24,
    parameter int GAIN_W       = 6,
    parameter int HOLD_SAMPLES = 12000,
    parameter int FADE_SAMPLES = 480,
    parameter int GAIN_MIN     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic              gate_en,
    input  logic [1:0]        gate_mode,
    input  logic [4:0]        thr_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic [GAIN_W-1:0] out_gain,
    output logic              gate_active
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] sample;
        logic [GAIN_W-1:0] gain;
        logic              active;
    } out_t;

    gate_mode_e        mode;
    logic              quiet;
    logic              act_next, act_now;
    logic [GAIN_W-1:0] held_next;
    logic              at_min;
    logic              mute;
    out_t              o_d, o_q;

    assign mode = gate_mode_e'(gate_mode);

    ngate_level #(.DATA_W(DATA_W)) u_level (
        .sample (in_sample),
        .code   (thr_code),
        .quiet  (quiet)
    );

    ngate_qual #(.HOLD_SAMPLES(HOLD_SAMPLES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (in_valid),
        .enable   (gate_en),
        .quiet    (quiet),
        .act_next (act_next),
        .act_now  (act_now)
    );

    ngate_fade #(
        .GAIN_W       (GAIN_W),
        .FADE_SAMPLES (FADE_SAMPLES),
        .GAIN_MIN     (GAIN_MIN)
    ) u_fade (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (in_valid),
        .mode      (mode),
        .act_next  (act_next),
        .act_now   (act_now),
        .gain_in   (gain_in),
        .held_next (held_next),
        .at_min    (at_min)
    );

    always_comb begin
        mute  = act_next && ((mode == GT_MUTE) || ((mode == GT_FADE_MUTE) && at_min));
        o_d       = o_q;
        o_d.valid = in_valid;
        if (in_valid) begin
            o_d.active = act_next;
            o_d.gain   = act_next ? held_next : gain_in;
            o_d.sample = mute ? '0 : in_sample;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid   = o_q.valid;
    assign out_sample  = o_q.sample;
    assign out_gain    = o_q.gain;
    assign gate_active = o_q.active;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sample) && $stable(out_gain)));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gate_en) |=>
            (out_sample == $past(in_sample) && out_gain == $past(gain_in) && !gate_active));

    assert_mute_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gate_en && mode == GT_MUTE) |=> (!gate_active || out_sample == '0));

endmodule

// File: tb/sim_audio_noise_gate.sv
`timescale 1ns/1ps
module sim_audio_noise_gate;
    localparam int DW   = 24;
    localparam int GW   = 6;
    localparam int HOLD = 8;
    localparam int FADE = 3;

    typedef struct {
        logic [DW-1:0] sample;
        logic [GW-1:0] gain;
        logic          active;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic [GW-1:0] gain_in = '0;
    logic          gate_en = 1'b0;
    logic [1:0]    gate_mode = 2'b00;
    logic [4:0]    thr_code = 5'd11;
    logic          out_valid;
    logic [DW-1:0] out_sample;
    logic [GW-1:0] out_gain;
    logic          gate_active;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    int m_cnt = 0, m_held = 0, m_fcnt = 0;
    bit m_act = 1'b0;

    always #2.5 clk = ~clk;

    audio_noise_gate #(
        .DATA_W(DW), .GAIN_W(GW), .HOLD_SAMPLES(HOLD), .FADE_SAMPLES(FADE), .GAIN_MIN(0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .gain_in(gain_in), .gate_en(gate_en), .gate_mode(gate_mode), .thr_code(thr_code),
        .out_valid(out_valid), .out_sample(out_sample), .out_gain(out_gain),
        .gate_active(gate_active)
    );

    // Threshold magnitudes stated in R4 for the codes the scenarios use.
    function automatic int thr_of(input logic [4:0] c);
        if (c == 5'd0)  return 1255;
        if (c == 5'd11) return 8389;
        return 265271;
    endfunction

    task automatic send(input int s, input int g, input string tag);
        exp_t e;
        int   mag;
        bit   quiet, mute;
        mag   = (s < 0) ? -s : s;
        quiet = (mag < thr_of(thr_code));
        if (!gate_en || !quiet) begin
            m_cnt = 0; m_act = 1'b0; m_fcnt = 0;
        end else if (!m_act) begin
            if (m_cnt == HOLD - 1) begin
                m_act = 1'b1; m_held = g; m_fcnt = 0;
            end else m_cnt++;
        end else if (gate_mode[1]) begin
            if (m_fcnt == FADE - 1) begin
                m_fcnt = 0;
                if (m_held > 0) m_held--;
            end else m_fcnt++;
        end
        mute     = m_act && (gate_mode == 2'b01 || (gate_mode == 2'b11 && m_held == 0));
        e.sample = mute ? '0 : DW'(s);
        e.gain   = m_act ? GW'(m_held) : GW'(g);
        e.active = m_act;
        e.tag    = tag;
        sb.push_back(e);
        in_valid  = 1'b1;
        in_sample = DW'(s);
        gain_in   = GW'(g);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL %s idle out_valid actual=%0b expected=0", tag, out_valid);
            end
        end
    endtask

    // Monitor: pops one expected item per output strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_sample !== e.sample || out_gain !== e.gain || gate_active !== e.active) begin
                    errors++;
                    $display("FAIL %s actual sample=%0d gain=%0d active=%0b expected sample=%0d gain=%0d active=%0b",
                             e.tag, $signed(out_sample), out_gain, gate_active,
                             $signed(e.sample), e.gain, e.active);
                end
            end
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sample !== '0 || out_gain !== '0 || gate_active !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%0b/%0d/%0d/%0b expected=0/0/0/0",
                     out_valid, out_sample, out_gain, gate_active);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || gate_active !== 1'b0) begin
            errors++;
            $display("FAIL R1 post-reset actual=%0b/%0b expected=0/0", out_valid, gate_active);
        end

        // R3: disabled gate passes quiet samples in mute mode untouched.
        gate_en = 1'b0; gate_mode = 2'b01; thr_code = 5'd11;
        for (int i = 0; i < 12; i++) send(10 + i, 33, "R3");
        idle(2, "R2");

        // R5/R7: hold mode engages on the 8th quiet sample and freezes gain.
        gate_en = 1'b1; gate_mode = 2'b00;
        for (int i = 0; i < 12; i++) send(-100 * i, (i < 9) ? 40 : 20, (i < 8) ? "R5" : "R7");
        // R4: magnitude just below threshold stays quiet, exactly at threshold releases.
        send(-8388, 25, "R4");
        send(8389, 25, "R6");
        send(5, 26, "R11");
        idle(3, "R2");
        // R4: negative loud, then full-scale negative.
        for (int i = 0; i < 8; i++) send(3, 30, "R5");
        send(-8389, 31, "R4");
        for (int i = 0; i < 8; i++) send(3, 30, "R5");
        send(-8388608, 31, "R4");

        // R5: broken quiet run never engages.
        for (int i = 0; i < 7; i++) send(1, 12, "R5");
        send(9000, 12, "R6");
        for (int i = 0; i < 7; i++) send(1, 12, "R5");
        send(9000, 12, "R6");

        // R8: mute mode.
        gate_mode = 2'b01;
        for (int i = 0; i < 12; i++) send(200 + i, 17, "R8");
        send(20000, 17, "R11");
        send(7, 18, "R11");

        // R9: fade mode from gain 5 down to floor and beyond.
        gate_mode = 2'b10;
        for (int i = 0; i < 30; i++) send(-50, 5, "R9");
        send(-9000, 44, "R11");

        // R10: fade then mute, gain 3.
        gate_mode = 2'b11;
        for (int i = 0; i < 22; i++) send(60, 3, "R10");
        send(8389, 3, "R11");
        send(61, 3, "R11");

        // R4: lowest and highest threshold codes.
        gate_mode = 2'b01; thr_code = 5'd0;
        for (int i = 0; i < 9; i++) send(1254, 9, "R4");
        send(1255, 9, "R4");
        thr_code = 5'd31;
        for (int i = 0; i < 9; i++) send(-265270, 9, "R4");
        send(265271, 9, "R4");

        // R3: disabling mid-gate releases immediately.
        thr_code = 5'd11;
        for (int i = 0; i < 9; i++) send(2, 8, "R8");
        gate_en = 1'b0;
        send(2, 8, "R3");
        send(2, 9, "R3");

        idle(4, "R2");
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing outputs actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule